// File: doc/BRIEF.md
# Byte-Port Frame Device Register Block

This block is the host-facing register slave of a simple frame device. A processor moves whole network frames through it one byte at a time. Received frames arrive on a byte stream and are collected in an internal buffer. Once the last byte is in, the receive byte count is loaded and a receive interrupt is raised. The host then pulls the frame out through a single-byte read port, and every read lowers the count by one.

For transmit, the host first programs a frame length, then pushes that many bytes into a single-byte write port. When the final byte arrives, the device takes the frame over, clears the transmit count and raises a transmit-done interrupt. It then streams the frame out on its transmit side with a valid/ready handshake.

One level interrupt line combines three sources: transmit-done, receive-available and a software test request. The receive and transmit flags are cleared by writing one to them. The test flag is cleared by reading it, and the test request is released by writing an all-zero word.

Top module: `fbp_regif`

## Requirements
- R1: Word addresses 0 and 1 read the low and high halves of the 64-bit `DEV_ID` parameter, and word address 6 reads the `IRQ_INFO` parameter. Host writes to these, to the busy word (2) and to the receive count word (3) change nothing.
- R2: Bit 0 of word address 2 (busy) reads 1 in any of these cases: a received frame is being filled, unread receive bytes remain, a transmit length is programmed and not yet complete, or a frame is still being streamed out. In all other cases it reads 0.
- R3: A frame byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high, and `rx_last` marks the final byte. From the next cycle, word address 3 reads the frame length in bytes, bit 1 of word address 5 reads 1 and `irq` is high.
- R4: Each host read of word address 7 returns the next received byte, in arrival order, in bits 7:0, with bits 31:8 at zero. Each such read lowers the receive count by one.
- R5: A read of word address 7 while the receive count is 0 returns 0, and the count stays at 0.
- R6: `rx_ready` is low while bit 1 of word address 5 is set or the receive count is non-zero. An offered frame is held off until both have been cleared.
- R7: Writing word address 4 sets the transmit length, which reads back there. Each write to word address 8 stores bits 7:0 as the next frame byte. On the write that supplies the programmed number of bytes, word address 4 reads 0 from the next cycle, and bit 0 of word address 5 and `irq` go high.
- R8: Writes to word address 8 while the transmit count is 0 are ignored: no byte is stored and no frame or event is produced.
- R9: A taken-over frame is presented on `tx_data` in write order while `tx_valid` is high, with `tx_len` equal to its length and `tx_last` on its final byte. Each byte is held stable while `tx_ready` is low. Writes to word address 4 during streaming are ignored.
- R10: In word address 5, writing 1 to bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle as the clearing write leaves the flag set.
- R11: Writing a word with bit 31 set to word address 5 raises the test request and `irq`. The first later read of word address 5 shows bit 31 as 1, and later reads show 0. The request, and with it `irq`, stays until the host writes the all-zero word to word address 5.
- R12: `irq` is the OR of receive-available, transmit-done and the test request. After reset all counts, flags and `irq` are 0, `tx_valid` is 0 and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Register word address |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (enables read side effects) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Offered byte ends the frame |
| rx_ready | output | 1 | Receive byte can be taken |
| tx_valid | output | 1 | Transmit byte presented |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Presented byte ends the frame |
| tx_len | output | $clog2(MAX_FRAME)+1 | Length of the frame being streamed |
| tx_ready | input | 1 | Transmit byte consumed |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with a 16-byte frame buffer and the default 65536-byte length limit, so a frame that fills the whole buffer is cheap to send. It also sets distinctive identifier and routing constants so that their halves cannot be confused. The small buffer brings into reach the held-off second frame while receive data is pending, the empty-port read after a full drain, and a clear of a flag that collides with a new receive event. Transmit stalls and length writes during streaming are also exercised.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [3:0] {
        REG_ID_LO    = 4'd0,
        REG_ID_HI    = 4'd1,
        REG_BUSY     = 4'd2,
        REG_RX_CNT   = 4'd3,
        REG_TX_CNT   = 4'd4,
        REG_IRQ_CTL  = 4'd5,
        REG_IRQ_INFO = 4'd6,
        REG_RX_PORT  = 4'd7,
        REG_TX_PORT  = 4'd8
    } reg_idx_e;

    localparam int IRQ_TX_BIT   = 0;
    localparam int IRQ_RX_BIT   = 1;
    localparam int IRQ_TEST_BIT = 31;

    typedef struct packed {
        logic test_flag;
        logic test_req;
        logic rx_done;
        logic tx_done;
    } irq_state_t;

    function automatic logic [31:0] byte_word(input logic [7:0] b);
        return {24'h0, b};
    endfunction

    function automatic logic [31:0] irq_word(input irq_state_t s);
        return {s.test_flag, 29'h0, s.rx_done, s.tx_done};
    endfunction

endpackage

// File: rtl/fbp_rx_path.sv
module fbp_rx_path #(
    parameter int BUF_DEPTH = 2048,
    parameter int LEN_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             hold,
    input  logic             pop,
    output logic [LEN_W-1:0] count,
    output logic [7:0]       rd_byte,
    output logic             done,
    output logic             active
);
    localparam int IDX_W = $clog2(BUF_DEPTH);

    logic [7:0]       mem [BUF_DEPTH];
    logic [LEN_W-1:0] fill_q;
    logic [LEN_W-1:0] count_q;
    logic [IDX_W-1:0] rd_q;
    logic             take;

    assign in_ready = !hold && (count_q == '0) && (fill_q < LEN_W'(BUF_DEPTH));
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (take) begin
            mem[fill_q[IDX_W-1:0]] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= '0;
            count_q <= '0;
            rd_q    <= '0;
        end else if (take) begin
            if (in_last) begin
                count_q <= fill_q + LEN_W'(1);
                fill_q  <= '0;
                rd_q    <= '0;
            end else begin
                fill_q <= fill_q + LEN_W'(1);
            end
        end else if (pop && (count_q != '0)) begin
            count_q <= count_q - LEN_W'(1);
            rd_q    <= rd_q + IDX_W'(1);
        end
    end

    assign count   = count_q;
    assign rd_byte = (count_q != '0) ? mem[rd_q] : 8'h00;
    assign done    = take && in_last;
    assign active  = (fill_q != '0) || (count_q != '0);

endmodule

// File: rtl/fbp_tx_path.sv
module fbp_tx_path #(
    parameter int BUF_DEPTH = 2048,
    parameter int LEN_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             byte_we,
    input  logic [7:0]       byte_in,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic [LEN_W-1:0] out_len,
    input  logic             out_ready,
    output logic [LEN_W-1:0] count,
    output logic             accepted,
    output logic             active
);
    localparam int IDX_W = $clog2(BUF_DEPTH);

    logic [7:0]       mem [BUF_DEPTH];
    logic [LEN_W-1:0] total_q;
    logic [LEN_W-1:0] wr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rd_q;
    logic             sending_q;
    logic             store;

    assign store    = byte_we && (total_q != '0);
    assign accepted = store && ((wr_q + LEN_W'(1)) == total_q);

    always_ff @(posedge clk) begin
        if (store) begin
            mem[wr_q[IDX_W-1:0]] <= byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q   <= '0;
            wr_q      <= '0;
            len_q     <= '0;
            rd_q      <= '0;
            sending_q <= 1'b0;
        end else begin
            if (len_we && !sending_q) begin
                total_q <= len_wdata;
                wr_q    <= '0;
            end else if (store) begin
                if (accepted) begin
                    total_q   <= '0;
                    wr_q      <= '0;
                    len_q     <= total_q;
                    rd_q      <= '0;
                    sending_q <= 1'b1;
                end else begin
                    wr_q <= wr_q + LEN_W'(1);
                end
            end
            if (sending_q && out_ready) begin
                if (out_last) begin
                    sending_q <= 1'b0;
                end else begin
                    rd_q <= rd_q + LEN_W'(1);
                end
            end
        end
    end

    assign out_valid = sending_q;
    assign out_data  = mem[rd_q[IDX_W-1:0]];
    assign out_last  = sending_q && ((rd_q + LEN_W'(1)) == len_q);
    assign out_len   = len_q;
    assign count     = total_q;
    assign active    = (total_q != '0) || sending_q;

endmodule

// File: rtl/fbp_irq_ctl.sv
module fbp_irq_ctl
    import fbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [31:0] wdata,
    input  logic       rd,
    input  logic       tx_evt,
    input  logic       rx_evt,
    output irq_state_t st,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.tx_done <= tx_evt || (st.tx_done && !(wr && wdata[IRQ_TX_BIT]));
            st.rx_done <= rx_evt || (st.rx_done && !(wr && wdata[IRQ_RX_BIT]));
            if (wr && wdata[IRQ_TEST_BIT]) begin
                st.test_flag <= 1'b1;
                st.test_req  <= 1'b1;
            end else begin
                if (rd) begin
                    st.test_flag <= 1'b0;
                end
                if (wr && (wdata == 32'h0)) begin
                    st.test_req <= 1'b0;
                end
            end
        end
    end

    assign irq = st.tx_done || st.rx_done || st.test_req;

endmodule

// File: rtl/fbp_regif.sv
module fbp_regif
    import fbp_pkg::*;
#(
    parameter logic [63:0] DEV_ID    = 64'h0000_0001_4642_5044,
    parameter logic [31:0] IRQ_INFO  = 32'h0000_0000,
    parameter int          BUF_DEPTH = 2048,
    parameter int          MAX_FRAME = 65536,
    localparam int         LEN_W     = $clog2(MAX_FRAME) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       host_addr,
    input  logic             host_we,
    input  logic             host_re,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [LEN_W-1:0] tx_len,
    input  logic             tx_ready,
    output logic             irq
);
    reg_idx_e         idx;
    irq_state_t       irq_st;
    logic [LEN_W-1:0] rx_cnt;
    logic [LEN_W-1:0] tx_cnt;
    logic [7:0]       rx_byte;
    logic             rx_evt, tx_evt;
    logic             rx_act, tx_act;
    logic             busy;

    assign idx  = reg_idx_e'(host_addr);
    assign busy = rx_act || tx_act;

    fbp_rx_path #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .in_ready (rx_ready),
        .hold     (irq_st.rx_done),
        .pop      (host_re && (idx == REG_RX_PORT)),
        .count    (rx_cnt),
        .rd_byte  (rx_byte),
        .done     (rx_evt),
        .active   (rx_act)
    );

    fbp_tx_path #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .len_we    (host_we && (idx == REG_TX_CNT)),
        .len_wdata (host_wdata[LEN_W-1:0]),
        .byte_we   (host_we && (idx == REG_TX_PORT)),
        .byte_in   (host_wdata[7:0]),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_len   (tx_len),
        .out_ready (tx_ready),
        .count     (tx_cnt),
        .accepted  (tx_evt),
        .active    (tx_act)
    );

    fbp_irq_ctl irq_i (
        .clk    (clk),
        .rst    (rst),
        .wr     (host_we && (idx == REG_IRQ_CTL)),
        .wdata  (host_wdata),
        .rd     (host_re && (idx == REG_IRQ_CTL)),
        .tx_evt (tx_evt),
        .rx_evt (rx_evt),
        .st     (irq_st),
        .irq    (irq)
    );

    always_comb begin
        case (idx)
            REG_ID_LO:    host_rdata = DEV_ID[31:0];
            REG_ID_HI:    host_rdata = DEV_ID[63:32];
            REG_BUSY:     host_rdata = {31'h0, busy};
            REG_RX_CNT:   host_rdata = 32'(rx_cnt);
            REG_TX_CNT:   host_rdata = 32'(tx_cnt);
            REG_IRQ_CTL:  host_rdata = irq_word(irq_st);
            REG_IRQ_INFO: host_rdata = IRQ_INFO;
            REG_RX_PORT:  host_rdata = byte_word(rx_byte);
            default:      host_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/fbp_regif_chk.sv
module fbp_regif_chk #(
    parameter int LEN_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       host_addr,
    input logic             host_we,
    input logic             host_re,
    input logic [31:0]      host_wdata,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             rx_last,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             irq,
    input logic             busy,
    input logic [LEN_W-1:0] rx_cnt,
    input logic             rx_flag,
    input logic             test_flag
);
    logic rx_end;
    assign rx_end = rx_valid && rx_ready && rx_last;

    p_rx_loaded_r3: assert property (@(posedge clk) disable iff (rst)
        rx_end |=> (rx_flag && (rx_cnt != '0) && irq));

    p_pop_step_r4: assert property (@(posedge clk) disable iff (rst)
        (host_re && (host_addr == 4'd7) && (rx_cnt != '0)) |=> (rx_cnt == $past(rx_cnt) - LEN_W'(1)));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (host_re && (host_addr == 4'd7) && (rx_cnt == '0) && !rx_end) |=> (rx_cnt == '0));

    p_rx_held_r6: assert property (@(posedge clk) disable iff (rst)
        rx_flag |-> !rx_ready);

    p_tx_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_busy_tx_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy);

    p_w1c_rx_r10: assert property (@(posedge clk) disable iff (rst)
        (host_we && (host_addr == 4'd5) && host_wdata[1] && !rx_end) |=> !rx_flag);

    p_test_once_r11: assert property (@(posedge clk) disable iff (rst)
        (host_re && (host_addr == 4'd5) && !(host_we && host_wdata[31])) |=> !test_flag);

endmodule

bind fbp_regif fbp_regif_chk #(.LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_wdata (host_wdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_last    (rx_last),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .irq        (irq),
    .busy       (busy),
    .rx_cnt     (rx_cnt),
    .rx_flag    (irq_st.rx_done),
    .test_flag  (irq_st.test_flag)
);

// File: tb/fbp_regif_tb_top.sv
module fbp_regif_tb_top;
    localparam int          BUF = 16;
    localparam int          LW  = 17;
    localparam logic [63:0] ID  = 64'h0123_4567_89AB_CDEF;
    localparam logic [31:0] INF = 32'h0000_0005;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    host_addr;
    logic          host_we, host_re;
    logic [31:0]   host_wdata, host_rdata;
    logic          rx_valid, rx_last, rx_ready;
    logic [7:0]    rx_data;
    logic          tx_valid, tx_last, tx_ready;
    logic [7:0]    tx_data;
    logic [LW-1:0] tx_len;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    fbp_regif #(.DEV_ID(ID), .IRQ_INFO(INF), .BUF_DEPTH(BUF), .MAX_FRAME(65536)) dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we), .host_re(host_re),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_len(tx_len), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        #1 d = host_rdata;
        @(posedge clk);
        #1 host_re = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(posedge clk);
        #1 host_we = 1'b0;
    endtask

    task automatic send_rx(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            logic acc;
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                rx_valid = 1'b1; rx_data = base + 8'(i); rx_last = (i == n - 1);
                #1 acc = rx_ready;
                @(posedge clk);
            end
        end
        #1 rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R12 irq after reset", {31'h0, irq}, 32'h0);
        check("R12 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
        check("R12 rx_ready after reset", {31'h0, rx_ready}, 32'h1);
        rd(4'd2, d); check("R12 busy after reset", d, 32'h0);
        rd(4'd3, d); check("R12 rx count after reset", d, 32'h0);
        rd(4'd4, d); check("R12 tx count after reset", d, 32'h0);
        rd(4'd5, d); check("R12 irq ctl after reset", d, 32'h0);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        rd(4'd0, d); check("R1 id low", d, ID[31:0]);
        rd(4'd1, d); check("R1 id high", d, ID[63:32]);
        rd(4'd6, d); check("R1 irq info", d, INF);
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd2, 32'h1); wr(4'd3, 32'h55);
        rd(4'd0, d); check("R1 id low after write", d, ID[31:0]);
        rd(4'd6, d); check("R1 info after write", d, INF);
        rd(4'd2, d); check("R1 busy after write", d, 32'h0);
        rd(4'd3, d); check("R1 rx count after write", d, 32'h0);
    endtask

    task automatic t_rx_basic();
        logic [31:0] d;
        send_rx(5, 8'hA0);
        rd(4'd3, d); check("R3 rx count loaded", d, 32'd5);
        rd(4'd5, d); check("R3 rx flag set", d, 32'h2);
        check("R3 irq on rx", {31'h0, irq}, 32'h1);
        check("R6 rx_ready low while pending", {31'h0, rx_ready}, 32'h0);
        rd(4'd2, d); check("R2 busy with unread bytes", d, 32'h1);
        for (int i = 0; i < 5; i++) begin
            rd(4'd7, d); check("R4 rx byte", d, 32'hA0 + 32'(i));
            rd(4'd3, d); check("R4 rx count step", d, 32'(4 - i));
        end
        rd(4'd7, d); check("R5 empty port read", d, 32'h0);
        rd(4'd3, d); check("R5 count stays zero", d, 32'h0);
        check("R6 still held by flag", {31'h0, rx_ready}, 32'h0);
        wr(4'd5, 32'h0);
        rd(4'd5, d); check("R10 write zero keeps flag", d, 32'h2);
        wr(4'd5, 32'h2);
        rd(4'd5, d); check("R10 write one clears flag", d, 32'h0);
        check("R12 irq low when all clear", {31'h0, irq}, 32'h0);
        check("R6 ready after clear", {31'h0, rx_ready}, 32'h1);
        rd(4'd2, d); check("R2 idle busy", d, 32'h0);
    endtask

    task automatic t_rx_full_hold();
        logic [31:0] d;
        send_rx(BUF, 8'h10);
        rd(4'd3, d); check("R3 full buffer count", d, 32'(BUF));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
            #1 check("R6 frame held off", {31'h0, rx_ready}, 32'h0);
            @(posedge clk);
        end
        #1 rx_valid = 1'b0; rx_last = 1'b0;
        for (int i = 0; i < BUF; i++) begin
            rd(4'd7, d); check("R4 full buffer byte", d, 32'h10 + 32'(i));
        end
        wr(4'd5, 32'h2);
        send_rx(3, 8'h40);
        rd(4'd3, d); check("R6 frame after release", d, 32'd3);
        for (int i = 0; i < 3; i++) begin
            rd(4'd7, d); check("R4 second frame byte", d, 32'h40 + 32'(i));
        end
        wr(4'd5, 32'h2);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        int got;
        wr(4'd4, 32'd4);
        rd(4'd4, d); check("R7 tx count readback", d, 32'd4);
        rd(4'd2, d); check("R2 busy while collecting", d, 32'h1);
        for (int i = 0; i < 3; i++) wr(4'd8, 32'hABCD_EF30 + 32'(i));
        rd(4'd4, d); check("R7 count before last byte", d, 32'd4);
        rd(4'd5, d); check("R7 no done before last byte", d, 32'h0);
        wr(4'd8, 32'h1234_5633);
        rd(4'd4, d); check("R7 count cleared", d, 32'h0);
        rd(4'd5, d); check("R7 tx done flag", d, 32'h1);
        check("R7 irq on tx done", {31'h0, irq}, 32'h1);
        check("R9 stall valid", {31'h0, tx_valid}, 32'h1);
        check("R9 stall data", {24'h0, tx_data}, 32'h30);
        wr(4'd4, 32'd7);
        rd(4'd4, d); check("R9 length write ignored while streaming", d, 32'h0);
        check("R9 data held during stall", {24'h0, tx_data}, 32'h30);
        got = 0;
        while (got < 4) begin
            @(negedge clk);
            tx_ready = 1'b1;
            #1;
            if (tx_valid) begin
                check("R9 tx byte", {24'h0, tx_data}, 32'h30 + 32'(got));
                check("R9 tx len", 32'(tx_len), 32'd4);
                check("R9 tx last", {31'h0, tx_last}, {31'h0, got == 3});
                got++;
            end
            @(posedge clk);
        end
        #1 tx_ready = 1'b0;
        check("R9 stream ended", {31'h0, tx_valid}, 32'h0);
        rd(4'd2, d); check("R2 idle after stream", d, 32'h0);
        wr(4'd8, 32'h99);
        wr(4'd8, 32'h98);
        check("R8 no frame from stray writes", {31'h0, tx_valid}, 32'h0);
        rd(4'd4, d); check("R8 count still zero", d, 32'h0);
        rd(4'd2, d); check("R8 not busy", d, 32'h0);
        wr(4'd5, 32'h1);
        rd(4'd5, d); check("R10 tx flag cleared", d, 32'h0);
        wr(4'd4, 32'd1);
        wr(4'd8, 32'h5A);
        check("R8 only programmed byte streamed", {24'h0, tx_data}, 32'h5A);
        @(negedge clk); tx_ready = 1'b1; @(posedge clk); #1 tx_ready = 1'b0;
        wr(4'd5, 32'h1);
    endtask

    task automatic t_test_irq();
        logic [31:0] d;
        wr(4'd5, 32'h8000_0000);
        check("R11 test raises irq", {31'h0, irq}, 32'h1);
        rd(4'd5, d); check("R11 first read shows test bit", d, 32'h8000_0000);
        rd(4'd5, d); check("R11 second read clear", d, 32'h0);
        check("R11 irq held after read", {31'h0, irq}, 32'h1);
        wr(4'd5, 32'h3);
        check("R11 irq held after nonzero write", {31'h0, irq}, 32'h1);
        wr(4'd5, 32'h0);
        check("R11 zero write releases", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77; rx_last = 1'b1;
        host_we = 1'b1; host_addr = 4'd5; host_wdata = 32'h2;
        @(posedge clk);
        #1 rx_valid = 1'b0; rx_last = 1'b0; host_we = 1'b0;
        rd(4'd5, d); check("R10 event beats clear", d, 32'h2);
        rd(4'd7, d); check("R4 race frame byte", d, 32'h77);
        wr(4'd5, 32'h2);
        check("R12 irq low at end", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1;
        host_addr = '0; host_we = 1'b0; host_re = 1'b0; host_wdata = '0;
        rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; tx_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_ident();
        t_rx_basic();
        t_rx_full_hold();
        t_tx();
        t_test_irq();
        t_clear_race();
        report();
        $finish;
    end

endmodule